// File: doc/BRIEF.md
# ULPI Link-Side Receive Decoder

This block sits on the link side of an 8-bit ULPI bus and interprets everything the PHY drives while it owns the bus (DIR high). Each cycle is sorted by the DIR/NXT pairing alone. It is one of three kinds: a bus turnaround cycle, a receive-command status byte, or a received packet byte. Packet bytes leave the block as a framed stream, with valid, first and last markers and a per-packet error flag.

The block also keeps a copy of the most recent receive-command status: line state, VBUS state, receive event and ID. It pulses a change flag whenever that copy takes a new value. A packet opens when DIR and NXT rise together, or when a data byte arrives while no packet is open. It closes when a status byte reports the receive event as inactive, or when DIR drops. Every data byte waits one cycle in a holding register, so the final byte can carry the last marker itself. The block does not drive STP, transmit, access PHY registers or check CRC.

Top module: `ulpi_rx_decoder`

## Requirements
- R1: The first cycle after DIR changes level is a turnaround cycle. In it the data bus is ignored: no status update, no change pulse and no byte is produced from it.
- R2: When DIR and NXT rise in the same cycle, a packet opens at once. The next data byte is emitted with `pkt_first` set.
- R3: When DIR is high past turnaround and NXT is low, the bus carries a status byte and it is captured. Field layout: bits [1:0] line state, bits [3:2] VBUS state, bits [5:4] receive event (00 inactive, 01 active, 11 error), bit 6 ID. Bit 7 is not stored.
- R4: `status_chg` is high for exactly one cycle, in the cycle after a captured status byte whose bits [6:0] differ from the stored copy. Otherwise it is low.
- R5: A byte sampled with DIR high and NXT high past turnaround is packet data. Bytes are emitted in arrival order, one cycle after the edge at which the next byte or the packet end is sampled.
- R6: Status bytes and idle NXT-low cycles between data bytes neither end nor split an open packet. Gaps of any length are tolerated.
- R7: A status byte with receive event 00 while a packet is open ends that packet. The held byte is emitted with `pkt_last` set.
- R8: DIR falling while a packet is open ends that packet. The held byte is emitted with `pkt_last` set.
- R9: A status byte with receive event 11 during a packet makes `pkt_err` high together with that packet's last byte. The next packet starts with the error cleared.
- R10: A data byte arriving while no packet is open, for example right after a status byte in the same DIR-high phase, opens a packet and is itself marked first. A one-byte packet carries first and last together.
- R11: After reset all stream outputs and `status_chg` are low and the status copy equals `STATUS_INIT`. An asynchronous reset during a packet discards it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | ULPI interface clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ulpi_dir | input | 1 | Bus direction, high when the PHY drives |
| ulpi_nxt | input | 1 | PHY next/data-valid strobe |
| ulpi_data | input | 8 | ULPI data bus as driven by the PHY |
| pkt_byte | output | 8 | Emitted packet byte, zero when not valid |
| pkt_valid | output | 1 | One-cycle strobe for `pkt_byte` |
| pkt_first | output | 1 | Emitted byte is the packet's first (PID) |
| pkt_last | output | 1 | Emitted byte is the packet's last |
| pkt_err | output | 1 | Packet saw a receive error, given with the last byte |
| line_state | output | 2 | Stored line state |
| vbus_state | output | 2 | Stored VBUS state |
| rx_event | output | 2 | Stored receive event |
| id_dig | output | 1 | Stored ID bit |
| status_chg | output | 1 | Pulse when the stored status changed |

## Verification
The bench builds the decoder with its default `STATUS_INIT` of zero. The reset check therefore compares against an all-zero status, and the first non-zero status byte must raise a change pulse. With that setting, a byte that differs only in the unstored bit 7 shows that such a byte raises no pulse. A mid-packet reset shows that the held byte is discarded rather than leaking into the stream. The vector table covers several packet shapes: high-speed back-to-back bytes closed by a status byte, gapped full-speed bytes closed by DIR falling, a packet opened from a data byte after a status byte and carrying an error, and a one-byte packet that follows with no DIR drop.

// File: rtl/ulpi_rx_decoder.sv
module ulpi_rx_decoder #(
  parameter logic [6:0] STATUS_INIT = 7'h00
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       ulpi_dir,
  input  logic       ulpi_nxt,
  input  logic [7:0] ulpi_data,
  output logic [7:0] pkt_byte,
  output logic       pkt_valid,
  output logic       pkt_first,
  output logic       pkt_last,
  output logic       pkt_err,
  output logic [1:0] line_state,
  output logic [1:0] vbus_state,
  output logic [1:0] rx_event,
  output logic       id_dig,
  output logic       status_chg
);

  localparam logic [1:0] EV_IDLE = 2'b00;
  localparam logic [1:0] EV_ERR  = 2'b11;

  logic       dir_q;
  logic       in_pkt;
  logic       first_pend;
  logic       hold_v;
  logic       hold_first;
  logic       err_q;
  logic [7:0] hold_b;
  logic [6:0] stat_q;

  wire ta       = ulpi_dir ^ dir_q;
  wire open_ta  = ulpi_dir & ~dir_q & ulpi_nxt;
  wire dir_fall = ~ulpi_dir & dir_q;
  wire cmd      = ulpi_dir & ~ta & ~ulpi_nxt;
  wire dat      = ulpi_dir & ~ta & ulpi_nxt;
  wire cmd_err  = cmd && (ulpi_data[5:4] == EV_ERR);
  wire cmd_end  = cmd && (ulpi_data[5:4] == EV_IDLE);
  wire close    = in_pkt & (cmd_end | dir_fall);

  assign line_state = stat_q[1:0];
  assign vbus_state = stat_q[3:2];
  assign rx_event   = stat_q[5:4];
  assign id_dig     = stat_q[6];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q      <= 1'b0;
      in_pkt     <= 1'b0;
      first_pend <= 1'b0;
      hold_v     <= 1'b0;
      hold_first <= 1'b0;
      hold_b     <= '0;
      err_q      <= 1'b0;
      stat_q     <= STATUS_INIT;
      status_chg <= 1'b0;
      pkt_byte   <= '0;
      pkt_valid  <= 1'b0;
      pkt_first  <= 1'b0;
      pkt_last   <= 1'b0;
      pkt_err    <= 1'b0;
    end else begin
      dir_q      <= ulpi_dir;
      status_chg <= 1'b0;
      pkt_byte   <= '0;
      pkt_valid  <= 1'b0;
      pkt_first  <= 1'b0;
      pkt_last   <= 1'b0;
      pkt_err    <= 1'b0;

      if (cmd) begin
        stat_q     <= ulpi_data[6:0];
        status_chg <= (ulpi_data[6:0] != stat_q);
      end

      if (open_ta) begin
        in_pkt     <= 1'b1;
        first_pend <= 1'b1;
        hold_v     <= 1'b0;
        err_q      <= 1'b0;
      end else if (dat) begin
        if (in_pkt && hold_v) begin
          pkt_byte  <= hold_b;
          pkt_valid <= 1'b1;
          pkt_first <= hold_first;
        end
        hold_v     <= 1'b1;
        hold_b     <= ulpi_data;
        hold_first <= first_pend | ~in_pkt;
        first_pend <= 1'b0;
        if (!in_pkt) begin
          in_pkt <= 1'b1;
          err_q  <= 1'b0;
        end
      end else if (close) begin
        if (hold_v) begin
          pkt_byte  <= hold_b;
          pkt_valid <= 1'b1;
          pkt_first <= hold_first;
          pkt_last  <= 1'b1;
          pkt_err   <= err_q;
        end
        in_pkt     <= 1'b0;
        hold_v     <= 1'b0;
        first_pend <= 1'b0;
        err_q      <= 1'b0;
      end else if (in_pkt && cmd_err) begin
        err_q <= 1'b1;
      end
    end
  end

  a_r1_rise_is_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (ulpi_dir && !dir_q) |=> (!pkt_valid && !status_chg));

  a_r4_chg_means_new_status: assert property (@(posedge clk) disable iff (!rst_n)
    status_chg |-> (stat_q != $past(stat_q)));

  a_r2_first_is_valid: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_first |-> pkt_valid);

  a_r7_last_is_valid: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_last |-> pkt_valid);

  a_r9_err_only_on_last: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_err |-> (pkt_last && pkt_valid));

  a_r5_no_double_first: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_first |=> !pkt_first);

endmodule

// File: tb/ulpi_rx_decoder_bench.sv
`timescale 1ns/1ps
module ulpi_rx_decoder_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       dir = 1'b0, nxt = 1'b0;
  logic [7:0] data = '0;
  logic [7:0] pkt_byte;
  logic       pkt_valid, pkt_first, pkt_last, pkt_err;
  logic [1:0] line_state, vbus_state, rx_event;
  logic       id_dig, status_chg;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2.5 clk = ~clk;

  ulpi_rx_decoder u_ulpi_rx_decoder (
    .clk(clk), .rst_n(rst_n), .ulpi_dir(dir), .ulpi_nxt(nxt), .ulpi_data(data),
    .pkt_byte(pkt_byte), .pkt_valid(pkt_valid), .pkt_first(pkt_first),
    .pkt_last(pkt_last), .pkt_err(pkt_err), .line_state(line_state),
    .vbus_state(vbus_state), .rx_event(rx_event), .id_dig(id_dig),
    .status_chg(status_chg)
  );

  // {dir, nxt, data, exp valid, first, last, err, exp byte}
  localparam int NV = 28;
  localparam logic [21:0] VEC [0:NV-1] = '{
    {2'b11, 8'h00, 4'b0000, 8'h00},  // R2 open on joint rise (turnaround)
    {2'b11, 8'hC3, 4'b0000, 8'h00},  // R5 PID held
    {2'b11, 8'h11, 4'b1100, 8'hC3},  // R2 first byte out
    {2'b11, 8'h22, 4'b1000, 8'h11},
    {2'b10, 8'h11, 4'b0000, 8'h00},  // R6 status byte inside packet
    {2'b11, 8'h33, 4'b1000, 8'h22},
    {2'b10, 8'h01, 4'b1010, 8'h33},  // R7 inactive event ends packet
    {2'b00, 8'h00, 4'b0000, 8'h00},
    {2'b00, 8'h00, 4'b0000, 8'h00},
    {2'b11, 8'h00, 4'b0000, 8'h00},  // R2 open again
    {2'b10, 8'h11, 4'b0000, 8'h00},  // R6 gap
    {2'b11, 8'hA5, 4'b0000, 8'h00},
    {2'b10, 8'h11, 4'b0000, 8'h00},  // R6 gap
    {2'b10, 8'h11, 4'b0000, 8'h00},  // R6 gap
    {2'b11, 8'h5A, 4'b1100, 8'hA5},
    {2'b10, 8'h12, 4'b0000, 8'h00},
    {2'b00, 8'hFF, 4'b1010, 8'h5A},  // R8 DIR fall ends packet
    {2'b00, 8'h00, 4'b0000, 8'h00},
    {2'b10, 8'hFF, 4'b0000, 8'h00},  // R1 turnaround data ignored
    {2'b10, 8'h01, 4'b0000, 8'h00},  // R3 status byte, no packet
    {2'b11, 8'h69, 4'b0000, 8'h00},  // R10 data opens packet
    {2'b11, 8'h77, 4'b1100, 8'h69},  // R10 first marker
    {2'b10, 8'h31, 4'b0000, 8'h00},  // R9 error event
    {2'b11, 8'h88, 4'b1000, 8'h77},
    {2'b10, 8'h00, 4'b1011, 8'h88},  // R9 error with last
    {2'b11, 8'hD2, 4'b0000, 8'h00},  // R10 back-to-back packet
    {2'b10, 8'h00, 4'b1110, 8'hD2},  // R10 one-byte packet, R9 error cleared
    {2'b00, 8'h00, 4'b0000, 8'h00}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(input logic d, input logic n, input logic [7:0] b);
    @(negedge clk);
    dir = d; nxt = n; data = b;
    @(posedge clk);
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 5);
    checks++;
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    finish_run();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    chk("R11 stream after reset", {pkt_valid, pkt_first, pkt_last, pkt_err, pkt_byte}, 12'h000);
    chk("R11 status after reset", {status_chg, id_dig, rx_event, vbus_state, line_state}, 8'h00);
    @(negedge clk);
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      step(VEC[i][21], VEC[i][20], VEC[i][19:12]);
      chk($sformatf("R5 row %0d", i),
          {pkt_valid, pkt_first, pkt_last, pkt_err, pkt_byte}, VEC[i][11:0]);
    end

    step(1'b1, 1'b0, 8'h5D);
    chk("R1 status kept in turnaround", {id_dig, rx_event, vbus_state, line_state}, 7'h00);
    chk("R1 no pulse in turnaround", status_chg, 1'b0);
    step(1'b1, 1'b0, 8'h5D);
    chk("R3 line state", line_state, 2'b01);
    chk("R3 vbus state", vbus_state, 2'b11);
    chk("R3 receive event", rx_event, 2'b01);
    chk("R3 id", id_dig, 1'b1);
    chk("R4 pulse on change", status_chg, 1'b1);
    step(1'b1, 1'b0, 8'hDD);
    chk("R4 no pulse for bit 7 only", status_chg, 1'b0);
    step(1'b1, 1'b0, 8'h1D);
    chk("R4 pulse on id change", status_chg, 1'b1);
    chk("R3 id cleared", id_dig, 1'b0);
    step(1'b1, 1'b0, 8'h1D);
    chk("R4 pulse lasts one cycle", status_chg, 1'b0);
    step(1'b0, 1'b0, 8'h00);

    step(1'b1, 1'b1, 8'h00);
    step(1'b1, 1'b1, 8'hE1);
    step(1'b1, 1'b1, 8'hE2);
    #1 rst_n = 1'b0;
    #1;
    chk("R11 reset mid packet", {pkt_valid, pkt_first, pkt_last, pkt_byte}, 11'h000);
    chk("R11 status back to init", {id_dig, rx_event, vbus_state, line_state}, 7'h00);
    @(negedge clk);
    dir = 1'b0; nxt = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    step(1'b1, 1'b0, 8'h00);
    step(1'b1, 1'b0, 8'h00);
    chk("R11 held byte discarded", pkt_valid, 1'b0);

    finish_run();
  end
endmodule